// File: doc/BRIEF.md
# Shoot-Through Dwell Sequencer for a Boosted Matrix Converter

This block turns one switching period of indirect space-vector modulation into a timed series of output-phase connections. It serves a direct matrix converter that has a quasi impedance-source boost stage. A controller supplies four active-vector dwell times, a shoot-through dwell time, a period length and two sector numbers, one for the rectifier stage and one for the inverter stage. All times are in clock ticks. For every tick the sequencer names the input phase that drives each output phase, or marks an output phase as shorted.

Shoot-through time comes only out of the zero-vector time, and the active dwell times are never changed. The requested shoot-through time is split between two single-phase shoot-through slots, one on each side of the active group. Only one output phase is shorted at a time, which keeps the number of bidirectional switch transitions low. The trigonometry that produces the dwell times is done upstream.

Top module: `st_dwell_seq`

## Requirements
- R1: While `rst_n` is low, `phase_sel` is 0, and `st_flag`, `per_strobe` and `sat_flag` are 0.
- R2: A period plays up to eight slots in this fixed order: leading zero, leading shoot-through, then actives AM, AN, BN, BM (lengths `dw_am`, `dw_an`, `dw_bn`, `dw_bm`), then trailing shoot-through and trailing zero. Each slot lasts exactly its length in ticks, and a slot of length 0 is skipped.
- R3: `phase_sel` holds three 2-bit codes: bits [1:0] for output A, [3:2] for B and [5:4] for C. The codes are 0 for input x, 1 for y, 2 for z and 3 for shorted. Rectifier sector k (1..6) picks rail pair alpha from the list (x,y),(x,z),(y,z),(y,x),(z,x),(z,y) at entry k and beta at entry k+1, wrapping to the first entry. Inverter sector k picks state mu at entry k and nu at entry k-1 of the list ABC = 101,100,110,010,011,001, wrapping. A 1 connects the output to the rail's positive input and a 0 to its negative input. AM uses (alpha,mu), AN (alpha,nu), BN (beta,nu) and BM (beta,mu). For rectifier sector 1 with inverter sector 2 this gives xyy, xyx, xzx, xzz.
- R4: The leading zero ties all outputs to alpha's negative input, and the trailing zero ties them to beta's negative input (yyy and zzz in the example).
- R5: In a shoot-through slot exactly one output is coded 3: the first output of A, B, C that mu connects to the positive rail. The other two outputs carry the neighbouring zero vector's input.
- R6: With A = the sum of the four active times and room = Ts - A (0 if negative), the granted shoot-through time is G = min(T0, room). The leading shoot-through slot gets floor(G/2) ticks and the trailing slot gets the rest. The zero time Tz = room - G is split with floor(Tz/2) ticks leading and the rest trailing.
- R7: If T0 > room, the shoot-through time is reduced to room, the zero time becomes 0, and `sat_flag` is 1 for that whole period. The active times are kept even when A > Ts, in which case the period lasts A ticks.
- R8: `per_strobe` is 1 only in the first tick of each period. A period lasts max(Ts, A) ticks. When Ts and A are both 0, it lasts one tick made of a single leading-zero tick.
- R9: Dwell times, period length and sectors are sampled only in the last tick of a period and apply to the whole next period. Changes at any other time do not affect the running period.
- R10: A sector value of 0 or 7 is treated as sector 1.
- R11: `st_flag` is 1 exactly in the ticks of a shoot-through slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dw_am | input | TW | Dwell of active AM, ticks |
| dw_an | input | TW | Dwell of active AN, ticks |
| dw_bn | input | TW | Dwell of active BN, ticks |
| dw_bm | input | TW | Dwell of active BM, ticks |
| dw_st | input | TW | Requested shoot-through time T0, ticks |
| per_len | input | TW | Switching period Ts, ticks |
| rect_sec | input | 3 | Rectifier-stage sector, 1..6 |
| inv_sec | input | 3 | Inverter-stage sector, 1..6 |
| phase_sel | output | 6 | Per-output connection codes |
| st_flag | output | 1 | A shoot-through slot is playing |
| per_strobe | output | 1 | First tick of a period |
| sat_flag | output | 1 | Shoot-through was reduced in this period |

## Verification
The hardest case to reach is the latching boundary: inputs must change while a period is running, and the running period must be shown to stay on its old values. The bench sets new values in the first tick of a period, briefly drives a third set in the middle, and restores the intended set before the last tick. It then checks the running period tick by tick against the old settings and the following period against the new ones. Saturation is reached both with partial shoot-through room and with an active sum longer than the period. The shortest possible period, one tick with all inputs zero, is also run.

// File: rtl/dwell_pkg.sv
package dwell_pkg;

    localparam logic [1:0] PH_X  = 2'd0;
    localparam logic [1:0] PH_Y  = 2'd1;
    localparam logic [1:0] PH_Z  = 2'd2;
    localparam logic [1:0] PH_ST = 2'd3;

    localparam int NSLOT = 8;

    localparam logic [3:0] SL_ZL   = 4'd0;
    localparam logic [3:0] SL_SL   = 4'd1;
    localparam logic [3:0] SL_A1   = 4'd2;
    localparam logic [3:0] SL_A2   = 4'd3;
    localparam logic [3:0] SL_A3   = 4'd4;
    localparam logic [3:0] SL_A4   = 4'd5;
    localparam logic [3:0] SL_ST   = 4'd6;
    localparam logic [3:0] SL_ZT   = 4'd7;
    localparam logic [3:0] SL_LOAD = 4'd8;

    typedef struct packed {
        logic [1:0] p;
        logic [1:0] n;
    } rail_t;

    // sector number 1..6 -> index 0..5, out-of-range values fold to 0
    function automatic logic [2:0] sector_index(input logic [2:0] s);
        if (s == 3'd0 || s == 3'd7) return 3'd0;
        return s - 3'd1;
    endfunction

    function automatic rail_t rect_rail(input logic [2:0] k);
        rail_t r;
        case (k)
            3'd0:    r = '{p: PH_X, n: PH_Y};
            3'd1:    r = '{p: PH_X, n: PH_Z};
            3'd2:    r = '{p: PH_Y, n: PH_Z};
            3'd3:    r = '{p: PH_Y, n: PH_X};
            3'd4:    r = '{p: PH_Z, n: PH_X};
            default: r = '{p: PH_Z, n: PH_Y};
        endcase
        return r;
    endfunction

    // bit 2 = output A, bit 0 = output C; 1 = positive rail
    function automatic logic [2:0] inv_state(input logic [2:0] k);
        logic [2:0] v;
        case (k)
            3'd0:    v = 3'b101;
            3'd1:    v = 3'b100;
            3'd2:    v = 3'b110;
            3'd3:    v = 3'b010;
            3'd4:    v = 3'b011;
            default: v = 3'b001;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/dwell_planner.sv
module dwell_planner
    import dwell_pkg::*;
#(
    parameter int TW = 12,
    parameter int LW = TW + 3
) (
    input  logic [TW-1:0]                dw_am,
    input  logic [TW-1:0]                dw_an,
    input  logic [TW-1:0]                dw_bn,
    input  logic [TW-1:0]                dw_bm,
    input  logic [TW-1:0]                dw_st,
    input  logic [TW-1:0]                per_len,
    output logic [NSLOT-1:0][LW-1:0]     slot_len,
    output logic                         st_sat
);

    logic [LW-1:0] act_sum;
    logic [LW-1:0] room;
    logic [LW-1:0] st_req;
    logic [LW-1:0] st_eff;
    logic [LW-1:0] zero_t;
    logic [LW-1:0] st_lead;
    logic [LW-1:0] z_lead;
    logic [LW-1:0] z_trail;

    always_comb begin
        act_sum = LW'(dw_am) + LW'(dw_an) + LW'(dw_bn) + LW'(dw_bm);
        room    = (LW'(per_len) > act_sum) ? (LW'(per_len) - act_sum) : '0;
        st_req  = LW'(dw_st);
        st_sat  = st_req > room;
        st_eff  = st_sat ? room : st_req;
        zero_t  = room - st_eff;
        st_lead = st_eff >> 1;
        z_lead  = zero_t >> 1;
        z_trail = zero_t - z_lead;
        // an empty period still needs one tick to reach the next boundary
        if (act_sum == '0 && room == '0) begin
            z_lead = LW'(1);
        end

        slot_len[SL_ZL[2:0]] = z_lead;
        slot_len[SL_SL[2:0]] = st_lead;
        slot_len[SL_A1[2:0]] = LW'(dw_am);
        slot_len[SL_A2[2:0]] = LW'(dw_an);
        slot_len[SL_A3[2:0]] = LW'(dw_bn);
        slot_len[SL_A4[2:0]] = LW'(dw_bm);
        slot_len[SL_ST[2:0]] = st_eff - st_lead;
        slot_len[SL_ZT[2:0]] = z_trail;
    end

endmodule

// File: rtl/conn_mapper.sv
module conn_mapper
    import dwell_pkg::*;
(
    input  logic [2:0] ridx,
    input  logic [2:0] iidx,
    input  logic [3:0] slot,
    output logic [5:0] phase_sel,
    output logic       st_active
);

    rail_t      rail_a;
    rail_t      rail_b;
    rail_t      rail_use;
    logic [2:0] st_mu;
    logic [2:0] st_nu;
    logic [2:0] st_use;
    logic [2:0] short_oh;
    logic       zero_mode;
    logic       short_mode;
    logic       idle;

    always_comb begin
        rail_a   = rect_rail(ridx);
        rail_b   = rect_rail((ridx == 3'd5) ? 3'd0 : 3'(ridx + 3'd1));
        st_mu    = inv_state(iidx);
        st_nu    = inv_state((iidx == 3'd0) ? 3'd5 : 3'(iidx - 3'd1));
        short_oh = st_mu[2] ? 3'b100 : (st_mu[1] ? 3'b010 : 3'b001);

        rail_use   = rail_a;
        st_use     = st_mu;
        zero_mode  = 1'b0;
        short_mode = 1'b0;
        idle       = 1'b0;
        case (slot)
            SL_ZL: zero_mode = 1'b1;
            SL_SL: short_mode = 1'b1;
            SL_A1: ;
            SL_A2: st_use = st_nu;
            SL_A3: begin rail_use = rail_b; st_use = st_nu; end
            SL_A4: rail_use = rail_b;
            SL_ST: begin rail_use = rail_b; short_mode = 1'b1; end
            SL_ZT: begin rail_use = rail_b; zero_mode = 1'b1; end
            default: idle = 1'b1;
        endcase
        st_active = short_mode;
    end

    for (genvar j = 0; j < 3; j++) begin : g_phase
        always_comb begin
            if (idle) begin
                phase_sel[2*j +: 2] = PH_X;
            end else if (short_mode && short_oh[2-j]) begin
                phase_sel[2*j +: 2] = PH_ST;
            end else if (zero_mode || short_mode) begin
                phase_sel[2*j +: 2] = rail_use.n;
            end else begin
                phase_sel[2*j +: 2] = st_use[2-j] ? rail_use.p : rail_use.n;
            end
        end
    end

endmodule

// File: rtl/st_dwell_seq.sv
module st_dwell_seq
    import dwell_pkg::*;
#(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] dw_am,
    input  logic [TW-1:0] dw_an,
    input  logic [TW-1:0] dw_bn,
    input  logic [TW-1:0] dw_bm,
    input  logic [TW-1:0] dw_st,
    input  logic [TW-1:0] per_len,
    input  logic [2:0]    rect_sec,
    input  logic [2:0]    inv_sec,
    output logic [5:0]    phase_sel,
    output logic          st_flag,
    output logic          per_strobe,
    output logic          sat_flag
);

    localparam int LW = TW + 3;

    typedef struct packed {
        logic [3:0]                slot;
        logic [LW-1:0]             cnt;
        logic [NSLOT-1:0][LW-1:0]  len;
        logic [2:0]                ridx;
        logic [2:0]                iidx;
        logic                      strobe;
        logic                      sat;
    } seq_t;

    seq_t s_d, s_q;

    logic [NSLOT-1:0][LW-1:0] plan_len;
    logic                     plan_sat;
    logic                     last_tick;
    logic [3:0]               nxt_slot;

    function automatic logic [3:0] next_nz(input logic [NSLOT-1:0][LW-1:0] l,
                                           input logic [3:0] from);
        logic [3:0] r;
        r = SL_LOAD;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (4'(i) >= from && l[i] != '0) r = 4'(i);
        end
        return r;
    endfunction

    dwell_planner #(.TW(TW), .LW(LW)) u_plan (
        .dw_am    (dw_am),
        .dw_an    (dw_an),
        .dw_bn    (dw_bn),
        .dw_bm    (dw_bm),
        .dw_st    (dw_st),
        .per_len  (per_len),
        .slot_len (plan_len),
        .st_sat   (plan_sat)
    );

    always_comb begin
        s_d        = s_q;
        s_d.strobe = 1'b0;
        last_tick  = (s_q.slot == SL_LOAD) ||
                     ((s_q.cnt + LW'(1)) >= s_q.len[s_q.slot[2:0]]);
        nxt_slot   = next_nz(s_q.len, 4'(s_q.slot + 4'd1));

        if (last_tick && (s_q.slot == SL_LOAD || nxt_slot == SL_LOAD)) begin
            s_d.len    = plan_len;
            s_d.sat    = plan_sat;
            s_d.ridx   = sector_index(rect_sec);
            s_d.iidx   = sector_index(inv_sec);
            s_d.slot   = next_nz(plan_len, 4'd0);
            s_d.cnt    = '0;
            s_d.strobe = 1'b1;
        end else if (last_tick) begin
            s_d.slot = nxt_slot;
            s_d.cnt  = '0;
        end else begin
            s_d.cnt = s_q.cnt + LW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.slot <= SL_LOAD;
        end else begin
            s_q <= s_d;
        end
    end

    conn_mapper u_map (
        .ridx      (s_q.ridx),
        .iidx      (s_q.iidx),
        .slot      (s_q.slot),
        .phase_sel (phase_sel),
        .st_active (st_flag)
    );

    assign per_strobe = s_q.strobe;
    assign sat_flag   = s_q.sat;

endmodule

// File: rtl/st_dwell_seq_chk.sv
module st_dwell_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] phase_sel,
    input logic       st_flag,
    input logic       per_strobe,
    input logic       sat_flag
);

    logic [1:0] ca, cb, cc;
    logic [2:0] sh;

    assign ca = phase_sel[1:0];
    assign cb = phase_sel[3:2];
    assign cc = phase_sel[5:4];
    assign sh = {ca == 2'd3, cb == 2'd3, cc == 2'd3};

    AST_SINGLE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sh) <= 1);  // R5

    AST_FLAG_TRACKS_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        st_flag == (sh != 3'b000));  // R11

    AST_SHORT_OTHERS_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        st_flag |-> ((sh[2] && cb == cc) || (sh[1] && ca == cc) || (sh[0] && ca == cb)));  // R5

    AST_SAT_HELD_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        !per_strobe |-> $stable(sat_flag));  // R9

    AST_SAT_NO_ZERO_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        sat_flag |-> !(ca == cb && cb == cc));  // R7

endmodule

bind st_dwell_seq st_dwell_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_sel  (phase_sel),
    .st_flag    (st_flag),
    .per_strobe (per_strobe),
    .sat_flag   (sat_flag)
);

// File: tb/sim_st_dwell_seq.sv
module sim_st_dwell_seq;

    localparam int CLK_PERIOD = 10;
    localparam int TW = 12;

    typedef struct {
        int am, an, bn, bm, st, per, rs, is;
    } cfg_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] dw_am, dw_an, dw_bn, dw_bm, dw_st, per_len;
    logic [2:0]    rect_sec, inv_sec;
    logic [5:0]    phase_sel;
    logic          st_flag, per_strobe, sat_flag;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;
    cfg_t cur;
    int   cur_len;

    logic [5:0] exp_ps [0:511];
    bit         exp_st [0:511];
    int         exp_len;
    bit         exp_sat;

    always #(CLK_PERIOD/2) clk = ~clk;

    st_dwell_seq #(.TW(TW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .dw_am(dw_am), .dw_an(dw_an), .dw_bn(dw_bn), .dw_bm(dw_bm),
        .dw_st(dw_st), .per_len(per_len),
        .rect_sec(rect_sec), .inv_sec(inv_sec),
        .phase_sel(phase_sel), .st_flag(st_flag),
        .per_strobe(per_strobe), .sat_flag(sat_flag)
    );

    task automatic chk(input bit ok, input string tag, input int got, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s got %0h exp %0h at %0t", tag, got, expv, $time);
        end
    endtask

    function automatic cfg_t mk(int am, int an, int bn, int bm, int st, int per, int rs, int is);
        cfg_t c;
        c.am = am; c.an = an; c.bn = bn; c.bm = bm;
        c.st = st; c.per = per; c.rs = rs; c.is = is;
        return c;
    endfunction

    task automatic drive(input cfg_t c);
        dw_am = TW'(c.am); dw_an = TW'(c.an); dw_bn = TW'(c.bn); dw_bm = TW'(c.bm);
        dw_st = TW'(c.st); per_len = TW'(c.per);
        rect_sec = 3'(c.rs); inv_sec = 3'(c.is);
    endtask

    // R3, R4, R5, R10: expected code of one slot
    function automatic logic [5:0] exp_code(int rs, int is, int slot);
        int         pp [6] = '{0, 0, 1, 1, 2, 2};
        int         nn [6] = '{1, 2, 2, 0, 0, 1};
        bit [2:0]   sv [6] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
        int         r, i, rp, rn, shp;
        bit [2:0]   mu, nu, st;
        bit         zero, shrt;
        logic [5:0] o;
        r = (rs < 1 || rs > 6) ? 0 : rs - 1;
        i = (is < 1 || is > 6) ? 0 : is - 1;
        mu = sv[i];
        nu = sv[(i + 5) % 6];
        rp = (slot >= 4) ? pp[(r + 1) % 6] : pp[r];
        rn = (slot >= 4) ? nn[(r + 1) % 6] : nn[r];
        st = (slot == 3 || slot == 4) ? nu : mu;
        zero = (slot == 0 || slot == 7);
        shrt = (slot == 1 || slot == 6);
        shp = mu[2] ? 0 : (mu[1] ? 1 : 2);
        for (int j = 0; j < 3; j++) begin
            if (shrt && j == shp)      o[2*j +: 2] = 2'd3;
            else if (zero || shrt)     o[2*j +: 2] = 2'(rn);
            else                       o[2*j +: 2] = st[2-j] ? 2'(rp) : 2'(rn);
        end
        return o;
    endfunction

    // R2, R6, R7, R8: expected tick list of one period
    task automatic build(input cfg_t c);
        int act, room, g, tz;
        int len [8];
        act = c.am + c.an + c.bn + c.bm;
        room = (c.per > act) ? c.per - act : 0;
        g = (c.st < room) ? c.st : room;
        exp_sat = (c.st > room);
        tz = room - g;
        len[0] = tz / 2; len[1] = g / 2;
        len[2] = c.am; len[3] = c.an; len[4] = c.bn; len[5] = c.bm;
        len[6] = g - g / 2; len[7] = tz - tz / 2;
        if (act == 0 && room == 0) len[0] = 1;
        exp_len = 0;
        for (int s = 0; s < 8; s++) begin
            for (int k = 0; k < len[s]; k++) begin
                exp_ps[exp_len] = exp_code(c.rs, c.is, s);
                exp_st[exp_len] = (s == 1 || s == 6);
                exp_len++;
            end
        end
    endtask

    // called at the negedge of a period's first tick; returns at the next one
    task automatic check_period(input cfg_t c, input string tag);
        build(c);
        for (int t = 0; t < exp_len; t++) begin
            chk(phase_sel == exp_ps[t], {tag, " phase_sel"}, int'(phase_sel), int'(exp_ps[t]));
            chk(st_flag == exp_st[t], "R11 st_flag", int'(st_flag), int'(exp_st[t]));
            chk(per_strobe == (t == 0), "R8 per_strobe", int'(per_strobe), int'(t == 0));
            chk(sat_flag == exp_sat, "R7 sat_flag", int'(sat_flag), int'(exp_sat));
            @(negedge clk);
        end
        chk(per_strobe == 1'b1, "R8 period length", int'(per_strobe), 1);
        cur = c;
        cur_len = exp_len;
    endtask

    task automatic run_cfg(input cfg_t c, input string tag);
        drive(c);
        repeat (cur_len) @(negedge clk);
        check_period(c, tag);
    endtask

    task automatic t_reset();
        cfg_t c = mk(3, 2, 4, 1, 4, 20, 1, 2);
        drive(c);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(phase_sel == 6'd0, "R1 phase_sel", int'(phase_sel), 0);
        chk(st_flag == 1'b0, "R1 st_flag", int'(st_flag), 0);
        chk(per_strobe == 1'b0, "R1 per_strobe", int'(per_strobe), 0);
        chk(sat_flag == 1'b0, "R1 sat_flag", int'(sat_flag), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_basic();
        cfg_t c = mk(3, 2, 4, 1, 4, 20, 1, 2);
        // R4: leading zero is yyy (code 1 on every output)
        chk(phase_sel == 6'b01_01_01, "R4 leading zero", int'(phase_sel), 'h15);
        check_period(c, "R3");
    endtask

    task automatic t_odd_split();
        run_cfg(mk(2, 3, 1, 4, 5, 22, 4, 5), "R6");
    endtask

    task automatic t_no_st();
        run_cfg(mk(2, 2, 2, 2, 0, 15, 3, 6), "R2");
    endtask

    task automatic t_sat_partial();
        run_cfg(mk(3, 2, 4, 1, 8, 14, 2, 3), "R7");
    endtask

    task automatic t_sat_stretch();
        run_cfg(mk(3, 2, 4, 1, 3, 6, 5, 1), "R7");
    endtask

    task automatic t_skip_active();
        run_cfg(mk(0, 3, 0, 2, 3, 11, 6, 4), "R2");
    endtask

    task automatic t_tiny();
        run_cfg(mk(0, 0, 0, 0, 0, 0, 1, 1), "R8");
        run_cfg(mk(0, 0, 0, 0, 0, 0, 2, 2), "R8");
    endtask

    task automatic t_bad_sector();
        run_cfg(mk(2, 1, 2, 1, 2, 10, 0, 7), "R10");
    endtask

    task automatic t_latch();
        cfg_t a = mk(2, 2, 2, 2, 4, 16, 1, 2);
        cfg_t b = mk(1, 3, 2, 4, 2, 14, 3, 5);
        cfg_t z = mk(5, 5, 5, 5, 9, 40, 6, 6);
        run_cfg(a, "R9");
        // new values land in the first tick of a running period of cfg a
        drive(b);
        fork
            begin
                repeat (4) @(negedge clk);
                drive(z);
                repeat (3) @(negedge clk);
                drive(b);
            end
            check_period(a, "R9");
        join
        check_period(b, "R9");
    endtask

    task automatic t_sweep();
        for (int r = 1; r <= 6; r++) begin
            for (int i = 1; i <= 6; i++) begin
                run_cfg(mk(1, 2, 1, 2, 2, 10, r, i), "R3");
            end
        end
    endtask

    initial begin
        t_reset();
        t_basic();
        t_odd_split();
        t_no_st();
        t_sat_partial();
        t_sat_stretch();
        t_skip_active();
        t_tiny();
        t_bad_sector();
        t_latch();
        t_sweep();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL R8 watchdog expired got 0 exp 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule